// File: doc/BRIEF.md
# Bus Arbitration Sequencer

This block carries one device through the arbitration phase of a parallel SCSI bus. The bus lines are active low and open drain, so the block never drives a line high: each line has an enable output that means "pull this line low", and the observed level of each line comes back as an active-low input. Software sets a level-sensitive arbitrate control bit. It also presents the device's own ID as a one-hot byte, with bit k set for ID k.

Once the arbitrate bit is set, the sequencer waits until BSY and SEL have both read released for a programmable number of clock cycles. It then pulls BSY low together with its own ID line and holds them for a programmable arbitration delay. At the end of that delay it samples the data lines. If any line of higher significance than its own ID is pulled low, another device has won: the block releases everything and reports a lost arbitration. Otherwise it pulls SEL low and waits a fixed bus-clear interval, then reports a win and keeps driving until software clears the arbitrate bit. The selection or reselection phase that follows belongs to other logic.

Clearing the arbitrate bit aborts the sequence at any point.

Top module: `scsiArbSeq`

## Requirements
- R1: After reset, no line is driven (`bsyOe`, `selOe` and `dataOe` are all zero) and the three status flags are zero.
- R2: After `arbitrate` rises, BSY and the ID line are driven only once BSY and SEL have both read high on `settleCount` consecutive clock edges, where a count of 0 acts as 1. Any busy sample restarts the count. On a bus that is already free, driving starts max(settleCount,1)+1 cycles after `arbitrate` is set.
- R3: While arbitrating, `bsyOe` is 1 and `dataOe` equals `ownId`, which is one-hot with bit k meaning ID k.
- R4: After driving for `arbDelayCount` cycles (0 acts as 1), the block samples `busDataN`. It loses if any bit above its own ID bit reads low. Low bits below its own ID have no effect on the outcome.
- R5: A low reading on `busSelN` while the block is arbitrating makes it lose at the next clock edge.
- R6: On a win, `selOe` rises in the cycle after the decision while `bsyOe` and `dataOe` are held. `flagWon` rises CLR_CYCLES cycles after `selOe`, and driving continues while `arbitrate` stays set.
- R7: On a loss, every line is released at the deciding clock edge, SEL is never driven, and `flagLost` stays 1 until `arbitrate` is cleared.
- R8: Clearing `arbitrate` releases every line and clears every flag at the next clock edge, from any state.
- R9: `flagBusy` is 1 while the block waits for a free bus, while it arbitrates and during the bus-clear interval. At most one of the three flags is 1 at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| arbitrate | input | 1 | Arbitrate control bit, level sensitive |
| ownId | input | DATA_W | Own ID, one-hot |
| settleCount | input | CNT_W | Free cycles required before driving |
| arbDelayCount | input | CNT_W | Arbitration delay in cycles |
| busBsyN | input | 1 | Observed BSY line, active low |
| busSelN | input | 1 | Observed SEL line, active low |
| busDataN | input | DATA_W | Observed data lines, active low |
| bsyOe | output | 1 | Pull BSY low |
| selOe | output | 1 | Pull SEL low |
| dataOe | output | DATA_W | Pull each data line low |
| flagBusy | output | 1 | Arbitration in progress |
| flagLost | output | 1 | Arbitration lost, sticky |
| flagWon | output | 1 | Arbitration won |

## Verification
On every cycle, the assertions check the following:
- SEL is never driven without BSY, and the data drive is only ever the own ID while BSY is driven.
- BSY rises only after a free-bus sample.
- A lost state drives nothing and stays sticky, the flags are mutually exclusive, and clearing the arbitrate bit releases everything.

The exact wait lengths, the priority decision for each ID against each set of competing lines, the restart on a busy bus and the bus-clear interval before a win can only be shown by the bench's timed scenarios.

// File: rtl/scsiArbPkg.sv
package scsiArbPkg;
  typedef enum logic [1:0] {
    LIM_SETTLE = 2'd0,
    LIM_ARB    = 2'd1,
    LIM_CLEAR  = 2'd2
  } limSel_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_ARB   = 3'd2,
    ST_CLEAR = 3'd3,
    ST_WON   = 3'd4,
    ST_LOST  = 3'd5
  } arbState_e;

  typedef struct packed {
    logic    cntClr;
    logic    cntInc;
    limSel_e limSel;
  } dpCtl_t;
endpackage

// File: rtl/scsiArbDatapath.sv
module scsiArbDatapath
  import scsiArbPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 8,
  parameter int CLR_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [CNT_W-1:0]  settleCount,
  input  logic [CNT_W-1:0]  arbDelayCount,
  input  logic [DATA_W-1:0] ownId,
  input  logic [DATA_W-1:0] busDataN,
  input  logic              busBsyN,
  input  logic              busSelN,
  output logic              limitDone,
  output logic              busFree,
  output logic              higherSeen
);
  localparam logic [CNT_W-1:0] ClrLimit = CNT_W'(CLR_CYCLES);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  limit;
  logic [DATA_W-1:0] higherMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (ctl.cntClr) cnt <= '0;
    else if (ctl.cntInc) cnt <= cnt + 1'b1;
  end

  always_comb begin
    case (ctl.limSel)
      LIM_SETTLE: limit = settleCount;
      LIM_ARB:    limit = arbDelayCount;
      default:    limit = ClrLimit;
    endcase
  end

  // a zero limit behaves as one
  assign limitDone = ({1'b0, cnt} + 1'b1) >= {1'b0, limit};
  assign busFree   = busBsyN && busSelN;

  // bits of higher significance than the own ID bit
  always_comb begin
    higherMask[0] = 1'b0;
    for (int i = 1; i < DATA_W; i++)
      higherMask[i] = higherMask[i-1] | ownId[i-1];
  end

  assign higherSeen = |(~busDataN & higherMask);
endmodule

// File: rtl/scsiArbControl.sv
module scsiArbControl
  import scsiArbPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   arbitrate,
  input  logic   limitDone,
  input  logic   busFree,
  input  logic   higherSeen,
  input  logic   busSelN,
  output dpCtl_t ctl,
  output logic   driveBsy,
  output logic   driveSel,
  output logic   flagBusy,
  output logic   flagLost,
  output logic   flagWon
);
  arbState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    if (!arbitrate) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  nextState = ST_WAIT;
        ST_WAIT:  if (busFree && limitDone) nextState = ST_ARB;
        ST_ARB: begin
          if (!busSelN)                      nextState = ST_LOST;
          else if (limitDone && higherSeen)  nextState = ST_LOST;
          else if (limitDone)                nextState = ST_CLEAR;
        end
        ST_CLEAR: if (limitDone) nextState = ST_WON;
        default:  nextState = state;
      endcase
    end
  end

  always_comb begin
    ctl.cntClr = (nextState != state) || (state == ST_WAIT && !busFree);
    ctl.cntInc = !ctl.cntClr;
    case (state)
      ST_ARB:   ctl.limSel = LIM_ARB;
      ST_CLEAR: ctl.limSel = LIM_CLEAR;
      default:  ctl.limSel = LIM_SETTLE;
    endcase
  end

  assign driveBsy = (state == ST_ARB) || (state == ST_CLEAR) || (state == ST_WON);
  assign driveSel = (state == ST_CLEAR) || (state == ST_WON);
  assign flagBusy = (state == ST_WAIT) || (state == ST_ARB) || (state == ST_CLEAR);
  assign flagLost = (state == ST_LOST);
  assign flagWon  = (state == ST_WON);
endmodule

// File: rtl/scsiArbSeq.sv
module scsiArbSeq
  import scsiArbPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 8,
  parameter int CLR_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              arbitrate,
  input  logic [DATA_W-1:0] ownId,
  input  logic [CNT_W-1:0]  settleCount,
  input  logic [CNT_W-1:0]  arbDelayCount,
  input  logic              busBsyN,
  input  logic              busSelN,
  input  logic [DATA_W-1:0] busDataN,
  output logic              bsyOe,
  output logic              selOe,
  output logic [DATA_W-1:0] dataOe,
  output logic              flagBusy,
  output logic              flagLost,
  output logic              flagWon
);
  dpCtl_t ctl;
  logic   limitDone, busFree, higherSeen, driveBsy, driveSel;

  scsiArbDatapath #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CLR_CYCLES(CLR_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .settleCount(settleCount), .arbDelayCount(arbDelayCount),
    .ownId(ownId), .busDataN(busDataN), .busBsyN(busBsyN), .busSelN(busSelN),
    .limitDone(limitDone), .busFree(busFree), .higherSeen(higherSeen)
  );

  scsiArbControl u_ctl (
    .clk(clk), .rstN(rstN), .arbitrate(arbitrate),
    .limitDone(limitDone), .busFree(busFree), .higherSeen(higherSeen),
    .busSelN(busSelN), .ctl(ctl),
    .driveBsy(driveBsy), .driveSel(driveSel),
    .flagBusy(flagBusy), .flagLost(flagLost), .flagWon(flagWon)
  );

  assign bsyOe  = driveBsy;
  assign selOe  = driveSel;
  assign dataOe = driveBsy ? ownId : '0;
endmodule

// File: rtl/scsiArbChecker.sv
module scsiArbChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              arbitrate,
  input logic [DATA_W-1:0] ownId,
  input logic              busBsyN,
  input logic              busSelN,
  input logic              bsyOe,
  input logic              selOe,
  input logic [DATA_W-1:0] dataOe,
  input logic              flagBusy,
  input logic              flagLost,
  input logic              flagWon
);
  a_r6_sel_with_bsy: assert property (@(posedge clk) disable iff (!rstN)
    selOe |-> bsyOe);

  a_r3_data_is_own_id: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe != '0) |-> (bsyOe && dataOe == ownId));

  a_r2_bsy_after_free: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bsyOe) |-> $past(busBsyN && busSelN));

  a_r7_lost_releases: assert property (@(posedge clk) disable iff (!rstN)
    flagLost |-> (!bsyOe && !selOe && dataOe == '0));

  a_r7_lost_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flagLost && arbitrate) |=> flagLost);

  a_r8_abort_release: assert property (@(posedge clk) disable iff (!rstN)
    !arbitrate |=> (!bsyOe && !selOe && dataOe == '0 && !flagBusy && !flagLost && !flagWon));

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flagBusy, flagLost, flagWon}));

  a_r6_won_drives_sel: assert property (@(posedge clk) disable iff (!rstN)
    flagWon |-> (selOe && bsyOe));
endmodule

bind scsiArbSeq scsiArbChecker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_scsiArbSeq.sv
module tb_scsiArbSeq;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 8;
  localparam int CW  = 8;
  localparam int CLR = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          arbitrate = 1'b0;
  logic [DW-1:0] ownId = 8'h01;
  logic [CW-1:0] settleCount = 8'd2;
  logic [CW-1:0] arbDelayCount = 8'd2;
  logic          busBsyN = 1'b1;
  logic          busSelN = 1'b1;
  logic [DW-1:0] busDataN = '1;
  logic          bsyOe, selOe, flagBusy, flagLost, flagWon;
  logic [DW-1:0] dataOe;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  scsiArbSeq #(.DATA_W(DW), .CNT_W(CW), .CLR_CYCLES(CLR)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit expectLose(input logic [DW-1:0] id, input logic [DW-1:0] others);
    for (int i = DW-1; i >= 0; i--) begin
      if (id[i]) return 1'b0;
      if (others[i]) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic int atLeastOne(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic releaseArb(input string req);
    arbitrate = 1'b0;
    busSelN = 1'b1;
    busBsyN = 1'b1;
    tick();
    chk(!bsyOe && !selOe && dataOe == 0 && !flagBusy && !flagLost && !flagWon, req,
        {bsyOe, selOe, flagBusy, flagLost, flagWon}, 0);
    tick();
  endtask

  // full attempt on a free bus; others = competing IDs pulling lines low
  task automatic runArb(input int idBit, input int s, input int d, input logic [DW-1:0] others);
    int  cyc;
    bit  lose;
    logic [DW-1:0] id;
    id = DW'(1) << idBit;
    ownId = id;
    settleCount = CW'(s);
    arbDelayCount = CW'(d);
    busDataN = ~others;
    lose = expectLose(id, others);
    arbitrate = 1'b1;
    cyc = 0;
    do begin
      tick();
      cyc++;
      if (!bsyOe) chk(flagBusy, "R9", flagBusy, 1);
    end while (!bsyOe && cyc < 60);
    chk(cyc == atLeastOne(s) + 1, "R2", cyc, atLeastOne(s) + 1);
    chk(dataOe == id && !selOe, "R3", dataOe, id);
    for (int k = 1; k < atLeastOne(d); k++) begin
      tick();
      chk(bsyOe && !selOe && flagBusy, "R4", {bsyOe, selOe}, 2);
    end
    tick();
    if (lose) begin
      chk(!bsyOe && !selOe && dataOe == 0 && flagLost && !flagBusy, "R7",
          {bsyOe, selOe, flagLost}, 1);
      tick();
      chk(flagLost && !selOe, "R7", flagLost, 1);
    end else begin
      chk(selOe && bsyOe && dataOe == id && flagBusy, "R6", {selOe, bsyOe}, 3);
      for (int k = 1; k < CLR; k++) tick();
      chk(!flagWon, "R6", flagWon, 0);
      tick();
      chk(flagWon && selOe && bsyOe && !flagBusy, "R6", flagWon, 1);
    end
    busDataN = '1;
    releaseArb("R8");
  endtask

  initial begin
    int cyc;
    void'($urandom(32'h5eed_0042));
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk(!bsyOe && !selOe && dataOe == 0 && !flagBusy && !flagLost && !flagWon, "R1",
        {bsyOe, selOe, flagBusy, flagLost, flagWon}, 0);
    rstN = 1'b1;
    tick();
    chk(!bsyOe && dataOe == 0, "R1", bsyOe, 0);

    // directed: top ID always wins, ID 0 loses, lower bits ignored
    runArb(7, 3, 2, 8'h7f);
    runArb(0, 1, 1, 8'h10);
    runArb(3, 2, 3, 8'h07);
    runArb(4, 0, 0, 8'h00);
    runArb(2, 2, 2, 8'h08);

    // R2: busy bus holds off driving; count restarts on release
    ownId = 8'h20; settleCount = 8'd3; arbDelayCount = 8'd2;
    busBsyN = 1'b0;
    arbitrate = 1'b1;
    for (int k = 0; k < 6; k++) tick();
    chk(!bsyOe && flagBusy, "R2", bsyOe, 0);
    busBsyN = 1'b1; tick(); tick();
    busSelN = 1'b0; tick();
    busSelN = 1'b1;
    cyc = 0;
    do begin tick(); cyc++; end while (!bsyOe && cyc < 60);
    chk(cyc == 3, "R2", cyc, 3);

    // R5: SEL seen during arbitration loses
    busSelN = 1'b0;
    tick();
    chk(flagLost && !bsyOe && dataOe == 0, "R5", {flagLost, bsyOe}, 2);
    releaseArb("R8");

    // R8: abort during arbitration window
    ownId = 8'h40; settleCount = 8'd1; arbDelayCount = 8'd10;
    arbitrate = 1'b1;
    tick(); tick(); tick();
    chk(bsyOe, "R3", bsyOe, 1);
    releaseArb("R8");

    // random mix
    for (int t = 0; t < 60; t++) begin
      int b, s, d;
      logic [DW-1:0] oth;
      b = $urandom_range(DW-1, 0);
      s = $urandom_range(5, 0);
      d = $urandom_range(6, 0);
      oth = DW'($urandom_range(255, 0));
      if ($urandom_range(2, 0) == 0) oth = '0;
      runArb(b, s, d, oth);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule